// File: doc/BRIEF.md
# Repeated-Subtraction Sequential Divider

This block divides one unsigned integer by another over several clock cycles. It holds a working remainder and a quotient counter. Each cycle it compares the working remainder with the stored divisor. When the remainder is not smaller, it takes the divisor away and adds one to the quotient. The first cycle in which the remainder falls below the divisor ends the operation. The working remainder is then the remainder, and the quotient counter holds the quotient. The number of cycles therefore grows with the quotient and not with the operand width.

A caller waits until `busy_o` is low, then pulses `start_i` for one cycle with both operands on the inputs. `done_o` pulses for one cycle when the results are valid. The results then stay on the outputs until the next accepted start. A zero divisor does not iterate. It finishes at once and raises `div_zero_o`.

The controller has three states. DV_IDLE waits for a start. DV_RUN subtracts once per cycle. DV_FIN presents `done_o` for one cycle. The transitions are:
- idle_to_run: start with a nonzero divisor.
- idle_to_fin: start with a zero divisor.
- run_stay: the remainder is greater than or equal to the divisor.
- run_to_fin: the remainder is smaller than the divisor.
- fin_to_idle: taken unconditionally.

Top module: `rsub_divider`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `div_zero_o` are 0, and `quotient_o` and `remainder_o` are 0.
- R2: A start sampled while `busy_o` is 0 captures both operands and clears the quotient to 0. `busy_o` is 1 from the next cycle through the cycle in which `done_o` is 1.
- R3: In each running cycle in which the working remainder is greater than or equal to the divisor, the remainder drops by the divisor and the quotient rises by one.
- R4: For a nonzero divisor, the final quotient equals dividend / divisor and the final remainder equals dividend % divisor, with the remainder below the divisor. `done_o` is 1 in the cycle that follows Q+2 rising edges after the start edge, where Q is the quotient.
- R5: A dividend smaller than the divisor, including a zero dividend, finishes with quotient 0, remainder equal to the dividend, and `done_o` after 2 edges.
- R6: A zero divisor raises `done_o` and `div_zero_o` one edge after the start. The quotient is then all ones and the remainder equals the dividend.
- R7: `done_o` is high for exactly one cycle, and `busy_o` is 0 in the cycle after it.
- R8: A start that arrives while `busy_o` is 1 is ignored. The running operation finishes with the results of its original operands.
- R9: While idle with no start, `quotient_o`, `remainder_o` and `div_zero_o` hold their values.
- R10: `div_zero_o` is 0 on the completion of any division with a nonzero divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; accepted only while idle |
| dividend_i | input | WIDTH | Unsigned dividend |
| divisor_i | input | WIDTH | Unsigned divisor |
| quotient_o | output | WIDTH | Quotient (all ones on zero divisor) |
| remainder_o | output | WIDTH | Remainder / working remainder |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| div_zero_o | output | 1 | Last operation had a zero divisor |

## Verification
The bench uses several kinds of operand pairs, and each tells a different fault apart:
- 5 by 2: the small worked case, which gives an exact two-step count.
- 200 by 7 and 100 by 100: a long run and an exact-multiple run, which show off-by-one faults in the stop test.
- 255 by 1: the largest quotient, which shows counter wrap or a truncated iteration.
- 3 by 9 and 0 by 5: no subtraction at all.
- 77 by 0 and 0 by 0: the zero-divisor exit.

A start injected mid-run with different operands shows whether the busy guard works. Latency is counted against Q+2 for each operation, so a missing or extra state is caught even when the values are right.

// File: rtl/div_pkg.sv
package div_pkg;

    typedef enum logic [1:0] {
        DV_IDLE = 2'd0,
        DV_RUN  = 2'd1,
        DV_FIN  = 2'd2
    } dv_state_t;

endpackage

// File: rtl/div_cmp_sub.sv
// Compare-and-subtract cell: flags rem >= div and forms rem - div.
module div_cmp_sub #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] rem_i,
    input  logic [WIDTH-1:0] div_i,
    output logic             ge_o,
    output logic [WIDTH-1:0] diff_o
);
    localparam int EXT = WIDTH + 1;

    logic [EXT-1:0] wide_diff;

    always_comb begin
        wide_diff = {1'b0, rem_i} - {1'b0, div_i};
        ge_o      = ~wide_diff[EXT-1];
        diff_o    = wide_diff[WIDTH-1:0];
    end
endmodule

// File: rtl/div_ctrl.sv
// Three-state sequencer of the divider.
module div_ctrl
    import div_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      start_i,
    input  logic      zero_div_i,
    input  logic      ge_i,
    output logic      load_o,
    output logic      zload_o,
    output logic      step_o,
    output logic      busy_o,
    output logic      done_o
);
    dv_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DV_IDLE: begin
                if (start_i) begin
                    state_d = zero_div_i ? DV_FIN : DV_RUN;
                end
            end
            DV_RUN: begin
                if (!ge_i) begin
                    state_d = DV_FIN;
                end
            end
            DV_FIN: begin
                state_d = DV_IDLE;
            end
            default: begin
                state_d = DV_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= DV_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        load_o  = 1'b0;
        zload_o = 1'b0;
        step_o  = 1'b0;
        busy_o  = 1'b0;
        done_o  = 1'b0;
        unique case (state_q)
            DV_IDLE: begin
                load_o  = start_i && !zero_div_i;
                zload_o = start_i && zero_div_i;
            end
            DV_RUN: begin
                busy_o = 1'b1;
                step_o = ge_i;
            end
            DV_FIN: begin
                busy_o = 1'b1;
                done_o = 1'b1;
            end
            default: begin
                busy_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/div_regs.sv
// Operand, remainder, quotient and flag registers.
module div_regs #(
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic             zload_i,
    input  logic             step_i,
    input  logic [WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0] divisor_i,
    input  logic [WIDTH-1:0] diff_i,
    output logic [WIDTH-1:0] rem_o,
    output logic [WIDTH-1:0] div_o,
    output logic [WIDTH-1:0] quo_o,
    output logic             dz_o
);
    localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};
    localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rem_o <= '0;
            div_o <= '0;
            quo_o <= '0;
            dz_o  <= 1'b0;
        end else if (load_i) begin
            rem_o <= dividend_i;
            div_o <= divisor_i;
            quo_o <= '0;
            dz_o  <= 1'b0;
        end else if (zload_i) begin
            rem_o <= dividend_i;
            div_o <= divisor_i;
            quo_o <= ONES;
            dz_o  <= 1'b1;
        end else if (step_i) begin
            rem_o <= diff_i;
            quo_o <= quo_o + ONE;
        end
    end
endmodule

// File: rtl/rsub_divider.sv
// Top level: sequential divider by repeated subtraction.
module rsub_divider #(
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0] divisor_i,
    output logic [WIDTH-1:0] quotient_o,
    output logic [WIDTH-1:0] remainder_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             div_zero_o
);
    logic             load, zload, step, ge, zero_div;
    logic [WIDTH-1:0] rem_q, div_q, quo_q, diff;
    logic             dz_q;

    assign zero_div = (divisor_i == '0);

    div_cmp_sub #(.WIDTH(WIDTH)) u_cmp (
        .rem_i  (rem_q),
        .div_i  (div_q),
        .ge_o   (ge),
        .diff_o (diff)
    );

    div_ctrl u_ctrl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (start_i),
        .zero_div_i (zero_div),
        .ge_i       (ge),
        .load_o     (load),
        .zload_o    (zload),
        .step_o     (step),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    div_regs #(.WIDTH(WIDTH)) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (load),
        .zload_i    (zload),
        .step_i     (step),
        .dividend_i (dividend_i),
        .divisor_i  (divisor_i),
        .diff_i     (diff),
        .rem_o      (rem_q),
        .div_o      (div_q),
        .quo_o      (quo_q),
        .dz_o       (dz_q)
    );

    assign quotient_o  = quo_q;
    assign remainder_o = rem_q;
    assign div_zero_o  = dz_q;
endmodule

// File: rtl/div_checker.sv
// Property checker attached to the divider top.
module div_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             start_i,
    input logic [WIDTH-1:0] quotient_o,
    input logic [WIDTH-1:0] remainder_o,
    input logic             busy_o,
    input logic             done_o,
    input logic             div_zero_o,
    input logic [WIDTH-1:0] div_q
);
    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o) |=> busy_o);

    p_quo_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !done_o) |=> (done_o ? $stable(quotient_o)
                                        : quotient_o == $past(quotient_o) + ONE));

    p_rem_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !done_o) |=> (done_o ? $stable(remainder_o)
                                        : remainder_o == $past(remainder_o) - div_q));

    p_rem_below_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !div_zero_o) |-> (remainder_o < div_q));

    p_zero_ones_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && div_zero_o) |-> (quotient_o == {WIDTH{1'b1}}));

    p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> (!done_o && !busy_o));

    p_done_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> busy_o);

    p_hold_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !start_i) |=> ($stable(quotient_o) && $stable(remainder_o)
                                   && $stable(div_zero_o)));
endmodule

bind rsub_divider div_checker #(.WIDTH(WIDTH)) u_div_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .quotient_o  (quotient_o),
    .remainder_o (remainder_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .div_zero_o  (div_zero_o),
    .div_q       (div_q)
);

// File: tb/test_rsub_divider.sv
`timescale 1ns/1ps
module test_rsub_divider;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] dvd = '0;
    logic [W-1:0] dvs = '0;
    logic [W-1:0] quo, rem;
    logic         busy, done, dz;

    always #4 clk = ~clk;

    rsub_divider #(.WIDTH(W)) i_rsub_divider (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .start_i     (start),
        .dividend_i  (dvd),
        .divisor_i   (dvs),
        .quotient_o  (quo),
        .remainder_o (rem),
        .busy_o      (busy),
        .done_o      (done),
        .div_zero_o  (dz)
    );

    typedef struct {
        int q;
        int r;
        int z;
        int lat;
    } exp_t;

    exp_t exp_q[$];
    int   n_run  = 0;
    int   n_fail = 0;
    bit   finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // driver: push expected item, pulse start; optional ignored start mid-run
    task automatic run_op(input int a, input int b, input int inject_at,
                          input int a2, input int b2);
        exp_t e;
        while (busy) begin
            @(posedge clk); #1;
        end
        if (b == 0) begin
            e.q = (1 << W) - 1; e.r = a; e.z = 1; e.lat = 1;
        end else begin
            e.q = a / b; e.r = a % b; e.z = 0; e.lat = a / b + 2;
        end
        exp_q.push_back(e);
        @(posedge clk); #1;
        start = 1'b1; dvd = W'(a); dvs = W'(b);
        @(posedge clk); #1;
        start = 1'b0;
        if (inject_at >= 0) begin
            repeat (inject_at) begin
                @(posedge clk); #1;
            end
            start = 1'b1; dvd = W'(a2); dvs = W'(b2);
            @(posedge clk); #1;
            start = 1'b0;
        end
        wait (exp_q.size() == 0);
        @(posedge clk); #1;
        // R9: outputs hold while idle
        begin
            logic [W-1:0] hq, hr;
            logic         hz;
            hq = quo; hr = rem; hz = dz;
            dvd = 8'h5A; dvs = 8'h03;
            repeat (3) begin
                @(posedge clk); #1;
            end
            chk(quo == hq && rem == hr && dz == hz, "R9", "idle hold quotient",
                int'(quo), int'(hq));
        end
    endtask

    // monitor: pops expected items on done
    initial begin
        int  cnt = 0;
        bit  counting = 0;
        bit  after_done = 0;
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (counting) begin
                    cnt++;
                    if (cnt == 1) chk(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
                    if (!done) chk(busy == 1'b1, "R2", "busy during run", int'(busy), 1);
                end
                if (after_done) begin
                    chk(!done && !busy, "R7", "done/busy after pulse",
                        int'({done, busy}), 0);
                    after_done = 0;
                end
                if (done) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R7", "unexpected done", 1, 0);
                    end else begin
                        e = exp_q.pop_front();
                        chk(int'(quo) == e.q, e.z ? "R6" : (e.q == 0 ? "R5" : "R4"),
                            "quotient", int'(quo), e.q);
                        chk(int'(rem) == e.r, e.z ? "R6" : (e.q == 0 ? "R5" : "R4"),
                            "remainder", int'(rem), e.r);
                        chk(int'(dz) == e.z, e.z ? "R6" : "R10", "div_zero flag",
                            int'(dz), e.z);
                        chk(cnt == e.lat, e.z ? "R6" : "R4", "latency", cnt, e.lat);
                    end
                    counting = 0;
                    after_done = 1;
                end
                if (start && !busy) begin
                    counting = 1;
                    cnt = 0;
                end
            end
        end
    end

    // watchdog
    initial begin
        #1_000_000;
        chk(1'b0, "R4", "watchdog expired", 0, 1);
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(!busy && !done && !dz && quo == 0 && rem == 0, "R1", "reset state",
            int'({busy, done, dz}) + int'(quo) + int'(rem), 0);
        rst_n = 1'b1;
        run_op(5, 2, -1, 0, 0);       // R4: worked case, q=2 r=1
        run_op(200, 7, -1, 0, 0);     // R3 R4: long run
        run_op(100, 100, -1, 0, 0);   // R4: exact multiple
        run_op(255, 1, -1, 0, 0);     // R4: largest quotient
        run_op(3, 9, -1, 0, 0);       // R5: no subtraction
        run_op(0, 5, -1, 0, 0);       // R5: zero dividend
        run_op(77, 0, -1, 0, 0);      // R6: zero divisor
        run_op(0, 0, -1, 0, 0);       // R6: zero by zero
        run_op(50, 6, 3, 9, 3);       // R8: start mid-run ignored
        run_op(40, 4, 0, 0, 0);       // R8: start right after accept ignored
        run_op(13, 13, -1, 0, 0);     // R10 after zero case
        report();
    end
endmodule